// File: doc/BRIEF.md
# Double-Buffered Timing NCO Parameter Bank

This block holds the phase offset and the frequency word for a timing numerically controlled oscillator. A host writes new values through a simple write port (address, data, write enable) into holding registers. The NCO itself only ever sees the active copies. Holding values move to the active copies only on a dedicated trigger, so a multi-word update reaches the NCO all at once.

The frequency is committed by a write to its own strobe address. The phase offset is committed by a write to a separate strobe address, or by a rising edge on an external sync input. The sync path only acts when a sync-enable bit in a small control register is set. The same control register holds a format bit. This bit tells the NCO whether the 8-bit phase offset is two's complement (covering -T/2 to +T/2 of one input sample period T) or offset binary (covering 0 to T). The bank exposes that bit directly.

Top module: `nco_param_bank`

## Requirements
- R1: While `rst` is high at a clock edge, both holding registers, both active registers, the control bits and both update flags become zero at that edge.
- R2: A write to address 0 loads `wr_data[7:0]` into the phase holding register, with bit 7 as the most significant bit. Bits above 7 are ignored, and `ph_active` does not change.
- R3: A write to address 2 copies the phase holding value into `ph_active` at that clock edge, whatever is on `wr_data`. `ph_upd` is high for the following cycle.
- R4: When control bit 0 (sync enable) is 1, a rising edge on `sync_in` commits the phase holding value. The edge passes a two-flop synchroniser and an edge detector, so `ph_active` changes at the third rising clock edge after `sync_in` rises. `ph_upd` pulses at that point.
- R5: When control bit 0 is 0, a rising edge on `sync_in` leaves `ph_active` unchanged and `ph_upd` low.
- R6: A `sync_in` level held high for many cycles causes exactly one transfer. Holding values written while it stays high remain pending.
- R7: A write to address 1 loads `wr_data[31:0]` into the frequency holding register without changing `fq_active`. A write to address 3 copies it into `fq_active` and pulses `fq_upd` for one cycle.
- R8: If a phase strobe write and an enabled sync edge fall in the same cycle, exactly one transfer of the current holding value occurs, and `ph_upd` is high for a single cycle.
- R9: Control register writes go to address 4. Bit 1 of this register selects the phase format (1 = two's complement, 0 = offset binary) and appears on `fmt_twos` from the edge that samples the write.
- R10: With `wr_en` low, no register changes, whatever is on the address and data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the host port |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| sync_in | input | 1 | Asynchronous external sync |
| ph_active | output | 8 | Active phase offset used by the NCO |
| fq_active | output | 32 | Active frequency word used by the NCO |
| fmt_twos | output | 1 | Phase format: 1 two's complement, 0 offset binary |
| ph_upd | output | 1 | One-cycle pulse after a phase transfer |
| fq_upd | output | 1 | One-cycle pulse after a frequency transfer |

## Verification
The two phase triggers, a strobe-address write and an enabled sync edge, can land in the same cycle. The bench provokes this by raising `sync_in`, counting two clock edges so that the detected edge is live, and then driving the strobe write so that the third edge samples both triggers. The result is judged as correct when `ph_active` holds the pending value after that edge, `ph_upd` is high for that one cycle, and `ph_upd` is low again on the next cycle.

// File: rtl/nco_bank_pkg.sv
package nco_bank_pkg;

   // Decoded target of a host write
   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_PH_HLD = 3'd1,
      SEL_FQ_HLD = 3'd2,
      SEL_PH_STB = 3'd3,
      SEL_FQ_STB = 3'd4,
      SEL_CTRL   = 3'd5
   } nco_sel_e;

   // Control register image
   typedef struct packed {
      logic fmt_twos;
      logic sync_en;
   } nco_ctrl_t;

endpackage

// File: rtl/nco_addr_dec.sv
module nco_addr_dec
   import nco_bank_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int ADR_PH    = 0,
   parameter int ADR_FQ    = 1,
   parameter int ADR_PHSTB = 2,
   parameter int ADR_FQSTB = 3,
   parameter int ADR_CTL   = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output nco_sel_e          sel
);

   localparam logic [ADDR_W-1:0] A_PH    = ADDR_W'(ADR_PH);
   localparam logic [ADDR_W-1:0] A_FQ    = ADDR_W'(ADR_FQ);
   localparam logic [ADDR_W-1:0] A_PHSTB = ADDR_W'(ADR_PHSTB);
   localparam logic [ADDR_W-1:0] A_FQSTB = ADDR_W'(ADR_FQSTB);
   localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(ADR_CTL);

   always_comb begin
      sel = SEL_NONE;
      if (wr_en) begin
         unique case (wr_addr)
            A_PH:    sel = SEL_PH_HLD;
            A_FQ:    sel = SEL_FQ_HLD;
            A_PHSTB: sel = SEL_PH_STB;
            A_FQSTB: sel = SEL_FQ_STB;
            A_CTL:   sel = SEL_CTRL;
            default: sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/nco_sync_edge.sv
module nco_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);

   localparam int MSB = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("nco_sync_edge: STAGES must be at least 2");
   end

   logic [MSB:0] chain_q;
   logic         last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[MSB-1:0], din};
         last_q  <= chain_q[MSB];
      end
   end

   assign rise = chain_q[MSB] & ~last_q;

   // R6: a level held high yields one detected edge only
   a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/nco_shadow_reg.sv
module nco_shadow_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         xfer,
   output logic [W-1:0] hold_q,
   output logic [W-1:0] act_q,
   output logic         upd_q
);

   if (W < 1) begin : g_bad_width
      $error("nco_shadow_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         act_q  <= '0;
         upd_q  <= 1'b0;
      end else begin
         if (ld)   hold_q <= ld_val;
         if (xfer) act_q  <= hold_q;
         upd_q <= xfer;
      end
   end

   // R1: reset clears both copies and the flag
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (hold_q == '0 && act_q == '0 && !upd_q));

   // R2: loading the holding copy alone leaves the active copy alone
   a_r2_load_keeps_active: assert property (@(posedge clk) disable iff (rst)
      (ld && !xfer) |=> $stable(act_q));

   // R3: a transfer takes the value that was pending before the edge
   a_r3_xfer_copies: assert property (@(posedge clk) disable iff (rst)
      xfer |=> (act_q == $past(hold_q) && upd_q));

endmodule

// File: rtl/nco_param_bank.sv
module nco_param_bank
   import nco_bank_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int PHASE_W     = 8,
   parameter int FREQ_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ADR_PH      = 0,
   parameter int ADR_FQ      = 1,
   parameter int ADR_PHSTB   = 2,
   parameter int ADR_FQSTB   = 3,
   parameter int ADR_CTL     = 4,
   parameter int BIT_SYNCEN  = 0,
   parameter int BIT_FMT     = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               sync_in,
   output logic [PHASE_W-1:0] ph_active,
   output logic [FREQ_W-1:0]  fq_active,
   output logic               fmt_twos,
   output logic               ph_upd,
   output logic               fq_upd
);

   localparam int NUM_ADR = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (PHASE_W > DATA_W || FREQ_W > DATA_W) begin : g_bad_fields
      $error("nco_param_bank: field wider than data bus");
   end
   if (BIT_SYNCEN >= DATA_W || BIT_FMT >= DATA_W || BIT_SYNCEN == BIT_FMT) begin : g_bad_bits
      $error("nco_param_bank: control bit positions invalid");
   end
   if (ADR_PH >= NUM_ADR || ADR_FQ >= NUM_ADR || ADR_PHSTB >= NUM_ADR ||
       ADR_FQSTB >= NUM_ADR || ADR_CTL >= NUM_ADR) begin : g_bad_range
      $error("nco_param_bank: address outside decode range");
   end
   if (ADR_PH == ADR_FQ || ADR_PH == ADR_PHSTB || ADR_PH == ADR_FQSTB ||
       ADR_PH == ADR_CTL || ADR_FQ == ADR_PHSTB || ADR_FQ == ADR_FQSTB ||
       ADR_FQ == ADR_CTL || ADR_PHSTB == ADR_FQSTB || ADR_PHSTB == ADR_CTL ||
       ADR_FQSTB == ADR_CTL) begin : g_bad_map
      $error("nco_param_bank: addresses overlap");
   end

   nco_sel_e  sel;
   nco_ctrl_t ctrl_q;
   logic      sync_rise;
   logic      sync_fire;
   logic      ph_xfer;
   logic      fq_xfer;
   logic [PHASE_W-1:0] ph_hold;
   logic [FREQ_W-1:0]  fq_hold;

   nco_addr_dec #(
      .ADDR_W   (ADDR_W),
      .ADR_PH   (ADR_PH),
      .ADR_FQ   (ADR_FQ),
      .ADR_PHSTB(ADR_PHSTB),
      .ADR_FQSTB(ADR_FQSTB),
      .ADR_CTL  (ADR_CTL)
   ) u_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .sel    (sel)
   );

   nco_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (sync_in),
      .rise(sync_rise)
   );

   // Control register
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (sel == SEL_CTRL) begin
         ctrl_q.sync_en  <= wr_data[BIT_SYNCEN];
         ctrl_q.fmt_twos <= wr_data[BIT_FMT];
      end
   end

   assign sync_fire = sync_rise & ctrl_q.sync_en;
   assign ph_xfer   = (sel == SEL_PH_STB) | sync_fire;
   assign fq_xfer   = (sel == SEL_FQ_STB);

   nco_shadow_reg #(.W(PHASE_W)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .ld    (sel == SEL_PH_HLD),
      .ld_val(wr_data[PHASE_W-1:0]),
      .xfer  (ph_xfer),
      .hold_q(ph_hold),
      .act_q (ph_active),
      .upd_q (ph_upd)
   );

   nco_shadow_reg #(.W(FREQ_W)) u_freq (
      .clk   (clk),
      .rst   (rst),
      .ld    (sel == SEL_FQ_HLD),
      .ld_val(wr_data[FREQ_W-1:0]),
      .xfer  (fq_xfer),
      .hold_q(fq_hold),
      .act_q (fq_active),
      .upd_q (fq_upd)
   );

   assign fmt_twos = ctrl_q.fmt_twos;

   // R5: a sync edge with the enable clear and no strobe changes nothing
   a_r5_sync_blocked: assert property (@(posedge clk) disable iff (rst)
      (sync_rise && !ctrl_q.sync_en && sel != SEL_PH_STB) |=>
         (!ph_upd && $stable(ph_active)));

   // R7: a frequency update flag follows only a frequency strobe write
   a_r7_fq_source: assert property (@(posedge clk) disable iff (rst)
      fq_upd |-> $past(wr_en && wr_addr == ADDR_W'(ADR_FQSTB)));

   // R10: no write enable means no holding or control change
   a_r10_idle_port: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(ph_hold) && $stable(fq_hold) && $stable(fmt_twos)));

endmodule

// File: tb/nco_param_bank_tb.sv
module nco_param_bank_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        sync_in = 1'b0;
   logic [7:0]  ph_active;
   logic [31:0] fq_active;
   logic        fmt_twos;
   logic        ph_upd;
   logic        fq_upd;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   nco_param_bank u_dut (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sync_in  (sync_in),
      .ph_active(ph_active),
      .fq_active(fq_active),
      .fmt_twos (fmt_twos),
      .ph_upd   (ph_upd),
      .fq_upd   (fq_upd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one write; returns after the sampling edge, at the next falling edge
   task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'hF; wr_data = 32'hDEAD_BEEF;
   endtask

   task automatic t_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      check("R1 ph_active", ph_active, 0);
      check("R1 fq_active", fq_active, 0);
      check("R1 fmt_twos", fmt_twos, 0);
      check("R1 ph_upd", ph_upd, 0);
      check("R1 fq_upd", fq_upd, 0);
   endtask

   task automatic t_phase_strobe();
      host_wr(4'd0, 32'hFFFF_FFA5);
      check("R2 active unchanged", ph_active, 0);
      check("R2 no flag", ph_upd, 0);
      host_wr(4'd2, 32'h1234_5678);
      check("R3 active after strobe", ph_active, 8'hA5);
      check("R3 flag high", ph_upd, 1);
      @(negedge clk);
      check("R3 flag one cycle", ph_upd, 0);
   endtask

   task automatic t_idle_port();
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'd0; wr_data = 32'h0000_0011;
      @(negedge clk); wr_addr = 4'd2;
      @(negedge clk); wr_addr = 4'd4; wr_data = 32'h3;
      @(negedge clk); wr_addr = 4'd3;
      @(negedge clk);
      wr_addr = 4'hF;
      check("R10 ph_active", ph_active, 8'hA5);
      check("R10 fmt", fmt_twos, 0);
      check("R10 fq_active", fq_active, 0);
      host_wr(4'd2, 0);
      check("R10 holding kept", ph_active, 8'hA5);
   endtask

   task automatic t_freq();
      host_wr(4'd1, 32'h8765_4321);
      check("R7 active unchanged", fq_active, 0);
      check("R7 no flag", fq_upd, 0);
      host_wr(4'd3, 32'h0);
      check("R7 active after strobe", fq_active, 32'h8765_4321);
      check("R7 flag", fq_upd, 1);
      check("R7 phase untouched", ph_upd, 0);
      @(negedge clk);
      check("R7 flag one cycle", fq_upd, 0);
   endtask

   task automatic t_format();
      host_wr(4'd4, 32'h2);
      check("R9 two's complement", fmt_twos, 1);
      host_wr(4'd4, 32'h0);
      check("R9 offset binary", fmt_twos, 0);
   endtask

   task automatic t_sync_disabled();
      host_wr(4'd4, 32'h0);
      host_wr(4'd0, 32'h3C);
      sync_in = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R5 no flag", ph_upd, 0);
      end
      check("R5 active kept", ph_active, 8'hA5);
      sync_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_sync_enabled();
      host_wr(4'd4, 32'h1);
      host_wr(4'd0, 32'h5A);
      sync_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R4 not yet", ph_active, 8'hA5);
      @(negedge clk);
      check("R4 transfer", ph_active, 8'h5A);
      check("R4 flag", ph_upd, 1);
      // R6: level still high, new pending value must stay pending
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h77;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'hF;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check("R6 no second pulse", ph_upd, 0);
      end
      check("R6 single transfer", ph_active, 8'h5A);
      sync_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_coincide();
      int pulses = 0;
      host_wr(4'd0, 32'hC3);
      @(negedge clk); sync_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd2; wr_data = 32'h0;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 4'hF;
      check("R8 value", ph_active, 8'hC3);
      check("R8 flag", ph_upd, 1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (ph_upd) pulses++;
      end
      check("R8 single pulse", pulses, 0);
      sync_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      wr_addr = 4'hF;
      t_reset();
      t_phase_strobe();
      t_idle_port();
      t_freq();
      t_format();
      t_sync_disabled();
      t_sync_enabled();
      t_coincide();
      t_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule